// File: doc/BRIEF.md
# NAND Flash Byte Bus Cycle Engine

This block runs single-byte transfers on an 8-bit asynchronous NAND flash bus. A caller presents a request with an operation code and a byte. The engine then plays out the strobe sequence for a command latch, an address latch, a data write or a data read. It drives the latch enables, the active-low write and read strobes and the direction of the shared data bus. A read returns the captured byte, and every transfer ends with a one-clock completion pulse.

Every strobe phase lasts `PHASE_CYC` clocks, counted by a small down-counter. A write costs three phases: bus zeroed with the write strobe low, byte driven with the strobe still low, then the strobe released with the byte held. A read costs five phases: release the bus, two phases with the read strobe low (the byte is sampled between them), one phase with the strobe high, and one phase after the bus is reclaimed. The caller controls chip select through `chip_en` and keeps it asserted across the command, address and data transfers of a page operation.

Top module: `nand_byte_engine`

## Requirements
- R1: While reset is held and after it is released, with no request, the chip select strobe is high, both latch enables are low, the write and read strobes are high, the bus direction output is 1 (driving), busy is 0 and done is 0.
- R2: Operation code 2'b00 (command) raises the command latch enable for the whole transfer, with the address latch enable low. The write strobe is low for the first two phases and high in the third. The driven bus value is 8'h00 in the first phase and the request byte in the second and third.
- R3: Operation code 2'b01 (address) follows the same write sequence as R2, with the address latch enable high and the command latch enable low.
- R4: Operation code 2'b10 (data write) follows the same write sequence as R2, with both latch enables low.
- R5: Operation code 2'b11 (data read) releases the bus (direction 0) for one phase. The read strobe is then low for two phases and high for one phase, still with the bus released. The bus is driven again for a fifth phase. `rdata` holds the bus value present at the end of the first read-strobe-low phase.
- R6: busy is high from the clock after a request is accepted until the transfer ends. done is high for exactly one clock, in the first clock with busy low again.
- R7: A request made while busy is high is ignored: no further strobe activity follows the current transfer.
- R8: The command and address latch enables are never high together.
- R9: The chip select strobe equals the inverse of `chip_en`, delayed by one clock.
- R10: Each phase lasts `PHASE_CYC` clocks. done appears 3*`PHASE_CYC` clocks after acceptance for a write and 5*`PHASE_CYC` clocks after acceptance for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Caller's chip select request |
| req | input | 1 | Start a transfer (accepted when idle) |
| op | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| wdata | input | 8 | Byte for command, address or data write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |
| rdata | output | 8 | Byte captured by the last read |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus value when driving |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data bus value from the device |

## Verification
The bench builds the engine with `PHASE_CYC` = 2. With that value every phase spans two clocks, so an off-by-one in the down-counter or in a phase boundary changes the trace. All four operations are swept over every one of the 256 byte values, and every output is compared clock by clock against a trace derived arithmetically from the phase index. A modelled device drives the bus only while the read strobe is low, so a capture at the wrong phase or a bus turnaround in the wrong place shows up as a wrong `rdata`. Some transfers get a second request mid-flight to show that it is ignored.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'b00,
        OP_ADDR = 2'b01,
        OP_WDAT = 2'b10,
        OP_RDAT = 2'b11
    } nfc_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_ZERO,
        ST_W_DRIVE,
        ST_W_HOLD,
        ST_R_TURN,
        ST_R_LOW1,
        ST_R_LOW2,
        ST_R_HIGH,
        ST_R_BACK
    } nfc_state_e;

    typedef struct packed {
        nfc_state_e st;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic       oe;
        logic [7:0] dout;
        logic [7:0] byte_v;
        logic [7:0] rdata;
        logic       done;
    } nfc_seq_s;

endpackage

// File: rtl/nfc_phase_timer.sv
module nfc_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nfc_cycle_fsm.sv
module nfc_cycle_fsm
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] op,
    input  logic [7:0] wdata,
    input  logic [7:0] dq_in,
    input  logic       phase_last,
    output logic       phase_start,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       oe,
    output logic [7:0] dout
);
    localparam nfc_seq_s RESET_VAL = '{
        st: ST_IDLE, cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1,
        oe: 1'b1, dout: 8'h00, byte_v: 8'h00, rdata: 8'h00, done: 1'b0
    };

    nfc_seq_s s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        phase_start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    phase_start = 1'b1;
                    s_d.byte_v  = wdata;
                    if (nfc_op_e'(op) == OP_RDAT) begin
                        s_d.st = ST_R_TURN;
                        s_d.oe = 1'b0;
                    end else begin
                        s_d.st   = ST_W_ZERO;
                        s_d.we_n = 1'b0;
                        s_d.dout = 8'h00;
                        s_d.cle  = (nfc_op_e'(op) == OP_CMD);
                        s_d.ale  = (nfc_op_e'(op) == OP_ADDR);
                    end
                end
            end
            ST_W_ZERO: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_W_DRIVE;
                s_d.dout    = s_q.byte_v;
            end
            ST_W_DRIVE: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_W_HOLD;
                s_d.we_n    = 1'b1;
            end
            ST_W_HOLD: if (phase_last) begin
                s_d.st   = ST_IDLE;
                s_d.cle  = 1'b0;
                s_d.ale  = 1'b0;
                s_d.done = 1'b1;
            end
            ST_R_TURN: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_R_LOW1;
                s_d.re_n    = 1'b0;
            end
            ST_R_LOW1: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_R_LOW2;
                s_d.rdata   = dq_in;
            end
            ST_R_LOW2: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_R_HIGH;
                s_d.re_n    = 1'b1;
            end
            ST_R_HIGH: if (phase_last) begin
                phase_start = 1'b1;
                s_d.st      = ST_R_BACK;
                s_d.oe      = 1'b1;
            end
            ST_R_BACK: if (phase_last) begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RESET_VAL;
        else        s_q <= s_d;
    end

    assign busy  = (s_q.st != ST_IDLE);
    assign done  = s_q.done;
    assign rdata = s_q.rdata;
    assign cle   = s_q.cle;
    assign ale   = s_q.ale;
    assign we_n  = s_q.we_n;
    assign re_n  = s_q.re_n;
    assign oe    = s_q.oe;
    assign dout  = s_q.dout;
endmodule

// File: rtl/nand_byte_engine.sv
module nand_byte_engine #(
    parameter int PHASE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       req,
    input  logic [1:0] op,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       nand_ce_n,
    output logic       nand_cle,
    output logic       nand_ale,
    output logic       nand_we_n,
    output logic       nand_re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);
    logic phase_start;
    logic phase_last;
    logic ce_n_d, ce_n_q;

    assign ce_n_d = ~chip_en;

    always_ff @(posedge clk) begin
        if (!rst_n) ce_n_q <= 1'b1;
        else        ce_n_q <= ce_n_d;
    end

    assign nand_ce_n = ce_n_q;

    nfc_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (phase_start),
        .last  (phase_last)
    );

    nfc_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .op          (op),
        .wdata       (wdata),
        .dq_in       (dq_in),
        .phase_last  (phase_last),
        .phase_start (phase_start),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .oe          (dq_oe),
        .dout        (dq_out)
    );
endmodule

// File: rtl/nfc_engine_checker.sv
module nfc_engine_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       dq_oe,
    input logic [7:0] dq_out
);
    // R1: idle engine leaves the bus quiet and driven
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && dq_oe));

    // R8: latch enables are mutually exclusive
    a_r8_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R5: no read strobe while the engine drives the bus
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !dq_oe);

    // R2: write strobe low only with the bus driven
    a_r2_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> dq_oe);

    // R4: byte stays put across the latching edge of the write strobe
    a_r4_byte_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> $stable(dq_out));

    // R6: completion is a single-clock pulse following a busy clock
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
endmodule

bind nand_byte_engine nfc_engine_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
);

// File: tb/nand_byte_engine_test.sv
module nand_byte_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       req = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] flash_byte = 8'h00;
    logic       busy, done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, dq_oe;
    logic [7:0] rdata, dq_out, dq_in;

    int checks = 0;
    int fails = 0;

    bit    tr_bad;
    string tr_nm;
    int    tr_k, tr_a, tr_e;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // device model: drives the bus only while the read strobe is low
    assign dq_in = nand_re_n ? 8'h00 : flash_byte;

    nand_byte_engine #(.PHASE_CYC(PH)) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .req(req), .op(op),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic note(input string nm, input int k, input int a, input int e);
        if (a != e && !tr_bad) begin
            tr_bad = 1'b1;
            tr_nm  = nm;
            tr_k   = k;
            tr_a   = a;
            tr_e   = e;
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] b, input bit poke);
        int    len;
        int    done_k;
        string tag;
        len    = (o == 2'b11) ? 5 * PH : 3 * PH;
        tag    = (o == 2'b00) ? "R2" : (o == 2'b01) ? "R3" : (o == 2'b10) ? "R4" : "R5";
        tr_bad = 1'b0;
        done_k = 0;
        @(negedge clk);
        req = 1'b1;
        op  = o;
        if (o == 2'b11) begin
            wdata      = ~b;
            flash_byte = b;
        end else begin
            wdata      = b;
            flash_byte = ~b;
        end
        @(posedge clk);
        for (int k = 1; k <= len + 1; k++) begin
            int ph;
            @(negedge clk);
            ph = (k - 1) / PH;
            if (done && done_k == 0) done_k = k;
            if (k <= len) begin
                note("busy", k, int'(busy), 1);
                note("done", k, int'(done), 0);
                if (o == 2'b11) begin
                    note("cle", k, int'(nand_cle), 0);
                    note("ale", k, int'(nand_ale), 0);
                    note("we_n", k, int'(nand_we_n), 1);
                    note("re_n", k, int'(nand_re_n), (ph == 1 || ph == 2) ? 0 : 1);
                    note("oe", k, int'(dq_oe), (ph >= 4) ? 1 : 0);
                    if (k >= 2 * PH + 1) note("rdata", k, int'(rdata), int'(b));
                end else begin
                    note("cle", k, int'(nand_cle), (o == 2'b00) ? 1 : 0);
                    note("ale", k, int'(nand_ale), (o == 2'b01) ? 1 : 0);
                    note("we_n", k, int'(nand_we_n), (ph >= 2) ? 1 : 0);
                    note("re_n", k, int'(nand_re_n), 1);
                    note("oe", k, int'(dq_oe), 1);
                    note("dq_out", k, int'(dq_out), (ph == 0) ? 0 : int'(b));
                end
            end else begin
                note("busy", k, int'(busy), 0);
                note("cle", k, int'(nand_cle), 0);
                note("ale", k, int'(nand_ale), 0);
                note("we_n", k, int'(nand_we_n), 1);
                note("re_n", k, int'(nand_re_n), 1);
                note("oe", k, int'(dq_oe), 1);
                if (o == 2'b11) note("rdata", k, int'(rdata), int'(b));
            end
            if (k == 1) req = 1'b0;
            if (poke && k == 2) begin
                req = 1'b1;
                op  = (o == 2'b11) ? 2'b00 : 2'b11;
            end
            if (poke && k == 3) req = 1'b0;
        end
        checks++;
        if (tr_bad) begin
            fails++;
            $display("FAIL %s op=%0d byte=%0d %s at clock %0d: actual %0d expected %0d",
                     tag, o, b, tr_nm, tr_k, tr_a, tr_e);
        end
        // R10: completion lands exactly after the counted phases
        check(done_k == len + 1, "R10", "done clock", done_k, len + 1);
        @(negedge clk);
        // R6: pulse lasts one clock and busy stays low
        check(!done && !busy, "R6", "done/busy after pulse", int'({done, busy}), 0);
        if (poke) begin
            bit quiet;
            quiet = 1'b1;
            for (int j = 0; j < 6 * PH; j++) begin
                @(negedge clk);
                if (busy || !nand_we_n || !nand_re_n) quiet = 1'b0;
            end
            // R7: the mid-flight request must not start another transfer
            check(quiet, "R7", "activity after ignored request", int'(!quiet), 0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(nand_ce_n == 1'b1, "R1", "ce_n in reset", int'(nand_ce_n), 1);
        check(!nand_cle && !nand_ale, "R1", "latches in reset", int'({nand_cle, nand_ale}), 0);
        check(nand_we_n && nand_re_n, "R1", "strobes in reset", int'({nand_we_n, nand_re_n}), 3);
        check(dq_oe == 1'b1, "R1", "bus drive in reset", int'(dq_oe), 1);
        check(!busy && !done, "R1", "busy/done in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && nand_we_n && nand_re_n && dq_oe, "R1", "idle after reset",
              int'({busy, nand_we_n, nand_re_n, dq_oe}), 7);

        // R9: chip select follows chip_en one clock later
        chip_en = 1'b1;
        #1;
        check(nand_ce_n == 1'b1, "R9", "ce_n before edge", int'(nand_ce_n), 1);
        @(negedge clk);
        check(nand_ce_n == 1'b0, "R9", "ce_n after edge", int'(nand_ce_n), 0);

        // R2 R3 R4 R5 R8: every operation over every byte value
        for (int o = 0; o < 4; o++) begin
            for (int v = 0; v < 256; v++) begin
                run_op(2'(o), 8'(v), (v % 64) == 7);
            end
        end

        chip_en = 1'b0;
        @(negedge clk);
        check(nand_ce_n == 1'b1, "R9", "ce_n released", int'(nand_ce_n), 1);
        finish_run();
    end
endmodule